// File: doc/BRIEF.md
# Processor-side interrupt acknowledge and completion interface

This block is the per-core register window of a multi-core interrupt controller. Each core reads an acknowledge register to claim the interrupt that an external arbiter has nominated for it, and writes an end-of-interrupt register to retire it. The block holds the pending and active state itself. Software interrupts have that state per pair of source core and target core. Private peripheral interrupts have it per core. Shared interrupts have one pending and one active bit each, plus the core that claimed them. Each core also has a priority mask, a binary point value and a read-only running priority.

The register port carries 32-bit words and a requesting core number. Read data comes back one cycle after the request. ID ranges are 0-15 for software interrupts, 16-31 for private peripheral interrupts and 32 to 32+NSPI-1 for shared interrupts. The arbiter supplies a candidate ID and a source core for each core, plus a priority byte for every ID. It receives the pending vectors and a one-cycle update strobe per core. Register word offsets (byte address bits 7:2) are 0 for the priority mask, 1 for the binary point, 2 for acknowledge, 3 for end-of-interrupt and 4 for running priority. Other offsets read zero and ignore writes.

Top module: `irq_cpu_if`

## Requirements
- R1: After reset every core reads a priority mask of 0xff, a binary point of BPR_MIN (2) and a running priority of 0xff, and an acknowledge returns 1023.
- R2: An acknowledge read returns, one cycle later with rsp_valid high, a word with the ID in bits 9:0 and the source core in bits 12:10. The source field is nonzero only for IDs 0-15.
- R3: If the candidate is not pending for the requesting core, or its priority is not below the mask, the acknowledge returns 1023 with source 0 and changes no state.
- R4: Acknowledging software interrupt n from source s on core t clears bit t+8*s of n's pending vector and sets that bit in its active vector. Other sources of the same n stay pending.
- R5: Acknowledging ID 16-31 on core c moves bit ID-16 of core c's private words from pending to active. The same ID on other cores is untouched.
- R6: An end-of-interrupt write (ID in bits 9:0, source in bits 12:10) clears the matching active bit. If that bit is not active, no state changes and eoi_err pulses high in the cycle after the write.
- R7: A binary point write keeps data bits 2:0 and raises any value below BPR_MIN to BPR_MIN.
- R8: Running priority reads the lowest priority value among the core's active interrupts, or 0xff when it has none.
- R9: A successful acknowledge or end-of-interrupt pulses arb_update for the requesting core only, in the cycle after the request. No other access pulses it.
- R10: The byte enables have no effect, and every access acts on the full word.
- R11: If a raise and an acknowledge of the same interrupt fall in the same cycle, the interrupt ends both active and pending.
- R12: A priority mask write keeps data bits 7:0. An acknowledge succeeds only if the candidate's priority is strictly below the mask.
- R13: A shared interrupt belongs to the core that acknowledged it. An end-of-interrupt for it from any other core is an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Register request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_core | input | CW | Requesting core |
| req_addr | input | 8 | Byte address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables (ignored) |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| eoi_err | output | 1 | End-of-interrupt for an ID that is not active |
| arb_id | input | NCORE*10 | Candidate ID per core |
| arb_src | input | NCORE*3 | Candidate source core per core |
| prio_i | input | NID*8 | Priority per ID |
| sgi_raise | input | 1 | Raise a software interrupt |
| sgi_raise_id | input | 4 | Software interrupt number |
| sgi_raise_src | input | 3 | Raising core |
| sgi_raise_tgt | input | NCORE | Target cores |
| ppi_raise | input | NCORE*16 | Private interrupt raise, 16 per core |
| spi_raise | input | NSPI | Shared interrupt raise |
| sgi_pend_o | output | 1024 | Software pending vectors, 64 bits per ID |
| ppi_pend_o | output | NCORE*16 | Private pending words |
| spi_pend_o | output | NSPI | Shared pending bits |
| arb_update | output | NCORE | Re-evaluate strobe per core |

## Verification
A raise from a device and an acknowledge of the same interrupt can land on the same clock edge. One clears the pending bit and the other sets it. The bench raises a shared interrupt, nominates it and then asserts its raise line in the same cycle as the acknowledge read. It judges the result at the ports: the read returns that ID, a completion for it then succeeds (so it was active), and a second acknowledge returns it again (so it stayed pending).

// File: rtl/irq_cpu_if.sv
module irq_cpu_if #(
  parameter int NCORE   = 4,
  parameter int NSPI    = 16,
  parameter int BPR_MIN = 2,
  parameter int CW      = $clog2(NCORE),
  parameter int NID     = 32 + NSPI
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [CW-1:0]        req_core,
  input  logic [7:0]           req_addr,
  input  logic [31:0]          req_wdata,
  input  logic [3:0]           req_be,
  output logic                 rsp_valid,
  output logic [31:0]          rsp_rdata,
  output logic                 eoi_err,
  input  logic [NCORE*10-1:0]  arb_id,
  input  logic [NCORE*3-1:0]   arb_src,
  input  logic [NID*8-1:0]     prio_i,
  input  logic                 sgi_raise,
  input  logic [3:0]           sgi_raise_id,
  input  logic [2:0]           sgi_raise_src,
  input  logic [NCORE-1:0]     sgi_raise_tgt,
  input  logic [NCORE*16-1:0]  ppi_raise,
  input  logic [NSPI-1:0]      spi_raise,
  output logic [1023:0]        sgi_pend_o,
  output logic [NCORE*16-1:0]  ppi_pend_o,
  output logic [NSPI-1:0]      spi_pend_o,
  output logic [NCORE-1:0]     arb_update
);
  localparam int SW = $clog2(NSPI);
  localparam logic [9:0] SPUR = 10'd1023;

  logic [15:0][63:0]       sgi_pend, sgi_act, sgi_pend_n, sgi_act_n;
  logic [NCORE-1:0][15:0]  ppi_pend, ppi_act, ppi_pend_n, ppi_act_n;
  logic [NSPI-1:0]         spi_pend, spi_act, spi_pend_n, spi_act_n;
  logic [NSPI-1:0][CW-1:0] spi_own, spi_own_n;
  logic [NCORE-1:0][7:0]   pmr_q;
  logic [NCORE-1:0][2:0]   bpr_q;

  logic [7:0] prio_a [NID];
  logic [9:0] arb_id_a [NCORE];
  logic [2:0] arb_src_a [NCORE];

  for (genvar k = 0; k < NID; k++) begin : g_prio
    assign prio_a[k] = prio_i[k*8 +: 8];
  end
  for (genvar c = 0; c < NCORE; c++) begin : g_arb
    assign arb_id_a[c]  = arb_id[c*10 +: 10];
    assign arb_src_a[c] = arb_src[c*3 +: 3];
  end

  logic [5:0] word;
  logic       rd, wr, is_ack, is_eoi;
  assign word   = req_addr[7:2];
  assign rd     = req_valid & ~req_write;
  assign wr     = req_valid & req_write;
  assign is_ack = rd && word == 6'd2;
  assign is_eoi = wr && word == 6'd3;

  logic [2:0] core3;
  assign core3 = 3'(req_core);

  logic [9:0] cid;
  logic [2:0] csrc;
  logic       c_sgi, c_ppi, c_spi, cand_pend;
  logic [7:0] cand_prio;
  logic [SW-1:0] cspi;
  logic       ack_ok;

  assign cid   = arb_id_a[req_core];
  assign csrc  = arb_src_a[req_core];
  assign c_sgi = cid < 10'd16;
  assign c_ppi = !c_sgi && cid < 10'd32;
  assign c_spi = !c_sgi && !c_ppi && 32'(cid) < NID;
  assign cspi  = SW'(cid - 10'd32);

  always_comb begin
    cand_pend = 1'b0;
    cand_prio = 8'hff;
    if (c_sgi)      cand_pend = 32'(csrc) < NCORE && sgi_pend[cid[3:0]][{csrc, core3}];
    else if (c_ppi) cand_pend = ppi_pend[req_core][cid[3:0]];
    else if (c_spi) cand_pend = spi_pend[cspi];
    if (c_sgi || c_ppi || c_spi) cand_prio = prio_a[$clog2(NID)'(cid)];
  end

  assign ack_ok = is_ack && cand_pend && cand_prio < pmr_q[req_core];

  logic [9:0] eid;
  logic [2:0] esrc;
  logic       e_sgi, e_ppi, e_spi, eoi_act, eoi_ok;
  logic [SW-1:0] espi;
  assign eid   = req_wdata[9:0];
  assign esrc  = req_wdata[12:10];
  assign e_sgi = eid < 10'd16;
  assign e_ppi = !e_sgi && eid < 10'd32;
  assign e_spi = !e_sgi && !e_ppi && 32'(eid) < NID;
  assign espi  = SW'(eid - 10'd32);

  always_comb begin
    eoi_act = 1'b0;
    if (e_sgi)      eoi_act = 32'(esrc) < NCORE && sgi_act[eid[3:0]][{esrc, core3}];
    else if (e_ppi) eoi_act = ppi_act[req_core][eid[3:0]];
    else if (e_spi) eoi_act = spi_act[espi] && spi_own[espi] == req_core;
  end
  assign eoi_ok = is_eoi && eoi_act;

  logic [63:0] cmask;
  logic [7:0]  rpr;
  always_comb begin
    cmask = '0;
    for (int s = 0; s < NCORE; s++) cmask[{3'(s), core3}] = 1'b1;
    rpr = 8'hff;
    for (int k = 0; k < 16; k++)
      if (|(sgi_act[k] & cmask) && prio_a[k] < rpr) rpr = prio_a[k];
    for (int k = 0; k < 16; k++)
      if (ppi_act[req_core][k] && prio_a[16+k] < rpr) rpr = prio_a[16+k];
    for (int n = 0; n < NSPI; n++)
      if (spi_act[n] && spi_own[n] == req_core && prio_a[32+n] < rpr) rpr = prio_a[32+n];
  end

  always_comb begin
    sgi_pend_n = sgi_pend;
    sgi_act_n  = sgi_act;
    ppi_pend_n = ppi_pend;
    ppi_act_n  = ppi_act;
    spi_pend_n = spi_pend;
    spi_act_n  = spi_act;
    spi_own_n  = spi_own;
    if (ack_ok) begin
      if (c_sgi) begin
        sgi_pend_n[cid[3:0]][{csrc, core3}] = 1'b0;
        sgi_act_n[cid[3:0]][{csrc, core3}]  = 1'b1;
      end else if (c_ppi) begin
        ppi_pend_n[req_core][cid[3:0]] = 1'b0;
        ppi_act_n[req_core][cid[3:0]]  = 1'b1;
      end else begin
        spi_pend_n[cspi] = 1'b0;
        spi_act_n[cspi]  = 1'b1;
        spi_own_n[cspi]  = req_core;
      end
    end
    if (eoi_ok) begin
      if (e_sgi)      sgi_act_n[eid[3:0]][{esrc, core3}] = 1'b0;
      else if (e_ppi) ppi_act_n[req_core][eid[3:0]] = 1'b0;
      else            spi_act_n[espi] = 1'b0;
    end
    if (sgi_raise)
      for (int t = 0; t < NCORE; t++)
        if (sgi_raise_tgt[t]) sgi_pend_n[sgi_raise_id][{sgi_raise_src, 3'(t)}] = 1'b1;
    for (int c = 0; c < NCORE; c++) ppi_pend_n[c] = ppi_pend_n[c] | ppi_raise[c*16 +: 16];
    spi_pend_n = spi_pend_n | spi_raise;
  end

  logic [31:0] rd_mux;
  always_comb begin
    case (word)
      6'd0:    rd_mux = {24'd0, pmr_q[req_core]};
      6'd1:    rd_mux = {29'd0, bpr_q[req_core]};
      6'd2:    rd_mux = ack_ok ? {19'd0, c_sgi ? csrc : 3'd0, cid} : {22'd0, SPUR};
      6'd4:    rd_mux = {24'd0, rpr};
      default: rd_mux = 32'd0;
    endcase
  end

  logic [2:0] bpr_w;
  assign bpr_w = 32'(req_wdata[2:0]) < BPR_MIN ? 3'(BPR_MIN) : req_wdata[2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sgi_pend   <= '0;
      sgi_act    <= '0;
      ppi_pend   <= '0;
      ppi_act    <= '0;
      spi_pend   <= '0;
      spi_act    <= '0;
      spi_own    <= '0;
      pmr_q      <= {NCORE{8'hff}};
      bpr_q      <= {NCORE{3'(BPR_MIN)}};
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      eoi_err    <= 1'b0;
      arb_update <= '0;
    end else begin
      sgi_pend   <= sgi_pend_n;
      sgi_act    <= sgi_act_n;
      ppi_pend   <= ppi_pend_n;
      ppi_act    <= ppi_act_n;
      spi_pend   <= spi_pend_n;
      spi_act    <= spi_act_n;
      spi_own    <= spi_own_n;
      if (wr && word == 6'd0) pmr_q[req_core] <= req_wdata[7:0];
      if (wr && word == 6'd1) bpr_q[req_core] <= bpr_w;
      rsp_valid  <= rd;
      rsp_rdata  <= rd ? rd_mux : 32'd0;
      eoi_err    <= is_eoi && !eoi_act;
      arb_update <= (ack_ok || eoi_ok) ? NCORE'(1) << req_core : '0;
    end
  end

  assign sgi_pend_o = sgi_pend;
  assign ppi_pend_o = ppi_pend;
  assign spi_pend_o = spi_pend;

  logic unused_ok;
  assign unused_ok = ^{req_be, req_addr[1:0], req_wdata[31:13]};
endmodule

// File: rtl/irq_cpu_if_chk.sv
module irq_cpu_if_chk #(
  parameter int NCORE   = 4,
  parameter int BPR_MIN = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_write,
  input logic [5:0]         word,
  input logic               rsp_valid,
  input logic [12:0]        rsp_lo,
  input logic               eoi_err,
  input logic [NCORE-1:0]   arb_update,
  input logic [NCORE*3-1:0] bpr_flat
);
  p_rsp_follows_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  p_rsp_only_reads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));

  p_spurious_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(word) == 6'd2 && rsp_lo[9:0] == 10'd1023) |-> rsp_lo[12:10] == 3'd0);

  p_err_after_eoi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_err |-> $past(req_valid && req_write && word == 6'd3));

  p_err_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_err |-> arb_update == '0);

  p_update_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(arb_update));

  for (genvar g = 0; g < NCORE; g++) begin : g_bpr
    p_bpr_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
      32'(bpr_flat[g*3 +: 3]) >= BPR_MIN);
  end
endmodule

bind irq_cpu_if irq_cpu_if_chk #(.NCORE(NCORE), .BPR_MIN(BPR_MIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .word(req_addr[7:2]), .rsp_valid(rsp_valid), .rsp_lo(rsp_rdata[12:0]),
  .eoi_err(eoi_err), .arb_update(arb_update), .bpr_flat(bpr_q)
);

// File: tb/irq_cpu_if_tb.sv
`timescale 1ns/1ps
module irq_cpu_if_tb;
  localparam int NCORE = 4;
  localparam int NSPI  = 16;
  localparam int NID   = 32 + NSPI;
  localparam int CW    = 2;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [CW-1:0] req_core = 0;
  logic [7:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic [3:0] req_be = 4'hf;
  logic rsp_valid, eoi_err;
  logic [31:0] rsp_rdata;
  logic [NCORE*10-1:0] arb_id;
  logic [NCORE*3-1:0] arb_src = 0;
  logic [NID*8-1:0] prio;
  logic sgi_raise = 0;
  logic [3:0] sgi_raise_id = 0;
  logic [2:0] sgi_raise_src = 0;
  logic [NCORE-1:0] sgi_raise_tgt = 0;
  logic [NCORE*16-1:0] ppi_raise = 0;
  logic [NSPI-1:0] spi_raise = 0;
  logic [1023:0] sgi_pend_o;
  logic [NCORE*16-1:0] ppi_pend_o;
  logic [NSPI-1:0] spi_pend_o;
  logic [NCORE-1:0] arb_update;

  irq_cpu_if #(.NCORE(NCORE), .NSPI(NSPI), .BPR_MIN(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_core(req_core), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .eoi_err(eoi_err),
    .arb_id(arb_id), .arb_src(arb_src), .prio_i(prio),
    .sgi_raise(sgi_raise), .sgi_raise_id(sgi_raise_id), .sgi_raise_src(sgi_raise_src),
    .sgi_raise_tgt(sgi_raise_tgt), .ppi_raise(ppi_raise), .spi_raise(spi_raise),
    .sgi_pend_o(sgi_pend_o), .ppi_pend_o(ppi_pend_o), .spi_pend_o(spi_pend_o),
    .arb_update(arb_update));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] rdat;
  logic [NCORE-1:0] upd;
  logic err, vld;

  localparam logic [7:0] A_PMR = 8'h00, A_BPR = 8'h04, A_ACK = 8'h08, A_EOI = 8'h0C, A_RPR = 8'h10;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus(bit w, int core, logic [7:0] a, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    req_valid = 1; req_write = w; req_core = CW'(core); req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 0; req_write = 0; req_be = 4'hf;
    rdat = rsp_rdata; upd = arb_update; err = eoi_err; vld = rsp_valid;
  endtask

  task automatic rd(int core, logic [7:0] a);
    bus(0, core, a, 0, 4'hf);
  endtask

  task automatic wr(int core, logic [7:0] a, logic [31:0] d);
    bus(1, core, a, d, 4'hf);
  endtask

  task automatic cand(int core, int id, int src);
    arb_id[core*10 +: 10] = 10'(id);
    arb_src[core*3 +: 3]  = 3'(src);
  endtask

  task automatic t_reset;
    for (int c = 0; c < NCORE; c++) begin
      rd(c, A_PMR); chk("R1 pmr", rdat, 32'hff);
      rd(c, A_BPR); chk("R1 bpr", rdat, 32'd2);
      rd(c, A_RPR); chk("R1 rpr", rdat, 32'hff);
    end
    rd(0, A_ACK); chk("R1 ack spurious", rdat, 32'd1023);
    chk("R2 rsp_valid", {31'd0, vld}, 32'd1);
    chk("R9 no update on spurious", {28'd0, upd}, 32'd0);
  endtask

  task automatic t_sgi;
    @(negedge clk);
    sgi_raise = 1; sgi_raise_id = 5; sgi_raise_src = 1; sgi_raise_tgt = 4'b0100;
    @(negedge clk);
    sgi_raise_src = 3;
    @(negedge clk);
    sgi_raise = 0;
    cand(2, 5, 1);
    rd(2, A_ACK); chk("R2 R4 sgi ack word", rdat, 32'h405);
    chk("R9 update core2", {28'd0, upd}, 32'h4);
    rd(2, A_RPR); chk("R8 rpr active sgi", rdat, 32'h40);
    rd(2, A_ACK); chk("R4 pending cleared", rdat, 32'd1023);
    cand(2, 5, 3);
    rd(2, A_ACK); chk("R4 other source kept", rdat, 32'hC05);
    wr(2, A_EOI, 32'h405);
    chk("R6 eoi ok", {31'd0, err}, 32'd0);
    chk("R9 update on eoi", {28'd0, upd}, 32'h4);
    wr(2, A_EOI, 32'h405);
    chk("R6 eoi not active err", {31'd0, err}, 32'd1);
    chk("R6 R9 no update on err", {28'd0, upd}, 32'd0);
    rd(2, A_RPR); chk("R8 rpr remaining src", rdat, 32'h40);
    wr(2, A_EOI, 32'hC05);
    rd(2, A_RPR); chk("R8 rpr idle", rdat, 32'hff);
  endtask

  task automatic t_ppi;
    @(negedge clk);
    ppi_raise[1*16 + 4] = 1; ppi_raise[3*16 + 4] = 1;
    @(negedge clk);
    ppi_raise = 0;
    cand(1, 20, 5); cand(3, 20, 0);
    rd(1, A_ACK); chk("R5 R2 ppi ack src zero", rdat, 32'h14);
    rd(3, A_ACK); chk("R5 other core kept", rdat, 32'h14);
    chk("R9 update core3", {28'd0, upd}, 32'h8);
    rd(1, A_ACK); chk("R5 ppi pending cleared", rdat, 32'd1023);
    rd(1, A_RPR); chk("R8 rpr ppi", rdat, 32'h30);
    wr(1, A_EOI, 32'h14); chk("R6 ppi eoi", {31'd0, err}, 32'd0);
    wr(3, A_EOI, 32'h14); chk("R6 ppi eoi core3", {31'd0, err}, 32'd0);
  endtask

  task automatic t_mask;
    @(negedge clk); spi_raise[8] = 1;
    @(negedge clk); spi_raise = 0;
    wr(0, A_PMR, 32'h190);
    rd(0, A_PMR); chk("R12 pmr low byte", rdat, 32'h90);
    cand(0, 40, 0);
    rd(0, A_ACK); chk("R12 R3 equal prio masked", rdat, 32'd1023);
    chk("R3 R9 no update", {28'd0, upd}, 32'd0);
    wr(0, A_PMR, 32'h91);
    rd(0, A_ACK); chk("R12 below mask acks", rdat, 32'h28);
    chk("R9 update core0", {28'd0, upd}, 32'h1);
  endtask

  task automatic t_owner;
    wr(1, A_EOI, 32'h28); chk("R13 foreign eoi err", {31'd0, err}, 32'd1);
    rd(0, A_RPR); chk("R13 R8 still active", rdat, 32'h90);
    wr(0, A_EOI, 32'h28); chk("R13 owner eoi ok", {31'd0, err}, 32'd0);
    rd(0, A_RPR); chk("R8 released", rdat, 32'hff);
  endtask

  task automatic t_bpr;
    wr(1, A_BPR, 32'hF5); rd(1, A_BPR); chk("R7 low bits", rdat, 32'd5);
    wr(1, A_BPR, 32'h1);  rd(1, A_BPR); chk("R7 clamp", rdat, 32'd2);
    wr(1, A_BPR, 32'hFF8); rd(1, A_BPR); chk("R7 clamp zero", rdat, 32'd2);
  endtask

  task automatic t_be;
    bus(1, 3, A_PMR, 32'h55, 4'h0);
    bus(0, 3, A_PMR, 0, 4'h0);
    chk("R10 byte enables ignored", rdat, 32'h55);
    wr(3, A_PMR, 32'hff);
  endtask

  task automatic t_collide;
    @(negedge clk); spi_raise[1] = 1;
    @(negedge clk); spi_raise = 0;
    cand(0, 33, 0);
    wr(0, A_PMR, 32'hff);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_core = 0; req_addr = A_ACK; spi_raise[1] = 1;
    @(negedge clk);
    req_valid = 0; spi_raise = 0;
    chk("R11 ack during raise", rsp_rdata, 32'd33);
    wr(0, A_EOI, 32'd33); chk("R11 became active", {31'd0, err}, 32'd0);
    rd(0, A_ACK); chk("R11 stayed pending", rdat, 32'd33);
    wr(0, A_EOI, 32'd33);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NID; k++) prio[k*8 +: 8] = 8'h80;
    prio[5*8 +: 8]  = 8'h40;
    prio[20*8 +: 8] = 8'h30;
    prio[40*8 +: 8] = 8'h90;
    prio[33*8 +: 8] = 8'h10;
    for (int c = 0; c < NCORE; c++) cand(c, 1023, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_sgi;
    t_ppi;
    t_mask;
    t_owner;
    t_bpr;
    t_be;
    t_collide;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule